// File: doc/BRIEF.md
# LFSR Stream Message Encryptor

This block turns a short text message, kept in its own 256-byte memory, into a 64-character encrypted frame. The message is stored with a bias, so each stored byte is the character code minus 0x20. A host loads the message bytes and three configuration bytes through a simple memory port while the block is idle, then pulses `start`. The sequencer reads a preamble length, a tap pattern and a seed. It then builds a frame of 64 characters: biased spaces (0x00), then the message, then more biased spaces. Each character is combined by XOR with successive states of a 7-bit linear feedback shift register, and the 64 results are written back into the upper half of the low region. `done` signals the end of the run, and the host then reads the results through the same port.

The block has one memory port, so it makes one access per clock. The host owns that port whenever the sequencer is idle, waiting, or finished. While the sequencer runs, it owns the port. Each frame character takes one read cycle and one write cycle.

Top module: `lfsr_msg_encryptor`

## Requirements
- R1: After reset `done` is low and the sequencer stays idle until started; while idle or finished a host write (`host_we`=1) stores `host_wdata` at `host_addr` on the clock edge, and `host_rdata` combinationally shows the byte at `host_addr`.
- R2: Configuration is read from fixed addresses: preamble length at 61, tap pattern at 62, seed at 63.
- R3: A preamble length below 10 is used as 10, and one above 26 is used as 26; values from 10 to 26 are used as they are.
- R4: The seed is the low 7 bits of the byte at address 63; if those bits are all zero, the value 1 is used instead. The tap pattern is the low 7 bits of address 62.
- R5: Keystream state 0 is the seed; state k+1 is {state k bits [5:0], XOR-reduction of (state k AND tap)}.
- R6: Frame position i (0..63) holds 0x00 when i is less than the preamble length P, and otherwise holds the byte at address i−P.
- R7: Output byte i is written at address 64+i and equals {0, frame[i] bits [6:0] XOR keystream state i}; its bit 7 is always 0.
- R8: `done` rises on the 132nd rising edge that samples `start` low after a start pulse, and it stays high until `start` or `rst` is asserted.
- R9: While `start` is high the sequencer is held waiting and `done` is low; an aborted run restarts from the beginning once `start` falls.
- R10: The sequencer writes only to addresses 64 to 127.
- R11: Host writes issued while the sequencer is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request; the run begins after it falls |
| host_we | input | 1 | Host write enable, honoured only while not running |
| host_addr | input | 8 | Host memory address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Byte at the shared port address |
| done | output | 1 | Frame finished |

## Verification
A wrong keystream state appears as a wrong output byte at that frame position and every later one, because the error feeds back into all following states. The host sees it on readback after `done`. A wrong preamble clamp or a wrong message offset shifts the whole message within the frame, so the first differing byte marks the fault position. A state-machine fault shows up in the exact `done` latency, counted edge by edge from the release of `start`. Bound properties catch faults at the cycle they occur: a stray low write, a set bit 7, a zero keystream state, an out-of-range preamble length, or a `done` that does not hold.

// File: rtl/lme_pkg.sv
package lme_pkg;

    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int KW        = 7;
    localparam int FRAME     = 64;
    localparam int IW        = $clog2(FRAME);
    localparam int PRE_MIN   = 10;
    localparam int PRE_MAX   = 26;

    localparam logic [AW-1:0] A_PRE  = AW'(61);
    localparam logic [AW-1:0] A_TAP  = AW'(62);
    localparam logic [AW-1:0] A_SEED = AW'(63);
    localparam logic [AW-1:0] A_OUT  = AW'(64);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_LEN,
        ST_TAP,
        ST_SEED,
        ST_FETCH,
        ST_EMIT,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_req_t;

    function automatic logic [KW-1:0] lfsr_next(input logic [KW-1:0] s,
                                                input logic [KW-1:0] t);
        return {s[KW-2:0], ^(s & t)};
    endfunction

    function automatic logic [KW-1:0] fix_seed(input logic [KW-1:0] s);
        return (s == '0) ? KW'(1) : s;
    endfunction

    function automatic logic [DW-1:0] clamp_pre(input logic [DW-1:0] v);
        if (v < DW'(PRE_MIN)) return DW'(PRE_MIN);
        if (v > DW'(PRE_MAX)) return DW'(PRE_MAX);
        return v;
    endfunction

endpackage

// File: rtl/lme_mem.sv
module lme_mem
    import lme_pkg::*;
(
    input  logic          clk,
    input  mem_req_t      req,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (req.we) store[req.addr] <= req.wdata;
    end

    always_comb rdata = store[req.addr];
endmodule

// File: rtl/lme_keygen.sv
module lme_keygen
    import lme_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tap_ld,
    input  logic [KW-1:0] tap_in,
    input  logic          seed_ld,
    input  logic [KW-1:0] seed_in,
    input  logic          adv,
    output logic [KW-1:0] key
);
    logic [KW-1:0] tap_q;
    logic [KW-1:0] key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
            key_q <= KW'(1);
        end else begin
            if (tap_ld) tap_q <= tap_in;
            if (seed_ld)  key_q <= fix_seed(seed_in);
            else if (adv) key_q <= lfsr_next(key_q, tap_q);
        end
    end

    assign key = key_q;
endmodule

// File: rtl/lme_seq.sv
module lme_seq
    import lme_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] rdata,
    input  logic [KW-1:0] key,
    output mem_req_t      req,
    output logic          own,
    output logic          tap_ld,
    output logic          seed_ld,
    output logic          adv,
    output logic          stream_on,
    output logic [DW-1:0] pre_len,
    output logic          done
);
    seq_st_e       state_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] pre_q;
    logic [KW-1:0] char_q;
    logic          done_q;

    logic [DW-1:0] idx_w;
    logic [DW-1:0] msg_off;
    logic          in_msg;

    assign idx_w   = {{(DW-IW){1'b0}}, idx_q};
    assign in_msg  = (idx_w >= pre_q);
    assign msg_off = idx_w - pre_q;

    always_comb begin
        req       = '0;
        tap_ld    = 1'b0;
        seed_ld   = 1'b0;
        adv       = 1'b0;
        own       = 1'b1;
        stream_on = 1'b0;
        case (state_q)
            ST_LEN:  req.addr = A_PRE;
            ST_TAP: begin
                req.addr = A_TAP;
                tap_ld   = 1'b1;
            end
            ST_SEED: begin
                req.addr = A_SEED;
                seed_ld  = 1'b1;
            end
            ST_FETCH: begin
                req.addr  = in_msg ? msg_off : '0;
                stream_on = 1'b1;
            end
            ST_EMIT: begin
                req.we    = 1'b1;
                req.addr  = A_OUT + idx_w;
                req.wdata = {{(DW-KW){1'b0}}, char_q ^ key};
                adv       = 1'b1;
                stream_on = 1'b1;
            end
            default: own = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pre_q   <= DW'(PRE_MIN);
            char_q  <= '0;
            done_q  <= 1'b0;
        end else if (start) begin
            state_q <= ST_ARM;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_ARM:  state_q <= ST_LEN;
                ST_LEN: begin
                    pre_q   <= clamp_pre(rdata);
                    state_q <= ST_TAP;
                end
                ST_TAP:  state_q <= ST_SEED;
                ST_SEED: begin
                    idx_q   <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    char_q  <= in_msg ? rdata[KW-1:0] : '0;
                    state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IW'(FRAME-1)) begin
                        state_q <= ST_FIN;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign pre_len = pre_q;
    assign done    = done_q;
endmodule

// File: rtl/lfsr_msg_encryptor.sv
module lfsr_msg_encryptor
    import lme_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          done
);
    mem_req_t      seq_req;
    mem_req_t      host_req;
    mem_req_t      mem_req;
    logic [DW-1:0] mem_rdata;
    logic          seq_own;
    logic          tap_ld;
    logic          seed_ld;
    logic          key_adv;
    logic          stream_on;
    logic [DW-1:0] pre_len;
    logic [KW-1:0] key_state;

    assign host_req.we    = host_we;
    assign host_req.addr  = host_addr;
    assign host_req.wdata = host_wdata;

    assign mem_req    = seq_own ? seq_req : host_req;
    assign host_rdata = mem_rdata;

    lme_mem u_mem (
        .clk   (clk),
        .req   (mem_req),
        .rdata (mem_rdata)
    );

    lme_keygen u_key (
        .clk     (clk),
        .rst     (rst),
        .tap_ld  (tap_ld),
        .tap_in  (mem_rdata[KW-1:0]),
        .seed_ld (seed_ld),
        .seed_in (mem_rdata[KW-1:0]),
        .adv     (key_adv),
        .key     (key_state)
    );

    lme_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rdata     (mem_rdata),
        .key       (key_state),
        .req       (seq_req),
        .own       (seq_own),
        .tap_ld    (tap_ld),
        .seed_ld   (seed_ld),
        .adv       (key_adv),
        .stream_on (stream_on),
        .pre_len   (pre_len),
        .done      (done)
    );
endmodule

// File: rtl/lme_checker.sv
module lme_checker
    import lme_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          own,
    input logic          wr,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          stream_on,
    input logic [DW-1:0] pre_len,
    input logic [KW-1:0] key
);
    assert_out_window_R10: assert property (@(posedge clk) disable iff (rst)
        (own && wr) |-> (addr >= A_OUT && addr <= AW'(127)));

    assert_msb_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (own && wr) |-> (wdata[DW-1] == 1'b0));

    assert_pre_range_R3: assert property (@(posedge clk) disable iff (rst)
        stream_on |-> (pre_len >= DW'(PRE_MIN) && pre_len <= DW'(PRE_MAX)));

    assert_key_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        stream_on |-> (key != '0));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);
endmodule

bind lfsr_msg_encryptor lme_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .done      (done),
    .own       (seq_own),
    .wr        (seq_req.we),
    .addr      (seq_req.addr),
    .wdata     (seq_req.wdata),
    .stream_on (stream_on),
    .pre_len   (pre_len),
    .key       (key_state)
);

// File: tb/tb_lfsr_msg_encryptor.sv
module tb_lfsr_msg_encryptor;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LATENCY    = 132;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       done;

    int checks = 0;
    int errors = 0;
    logic [7:0] img [64];

    lfsr_msg_encryptor dut (
        .clk(clk), .rst(rst), .start(start), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic load(input string s, input logic [7:0] pre,
                        input logic [7:0] tap, input logic [7:0] seed);
        for (int k = 0; k < 61; k++) img[k] = 8'h00;
        for (int k = 0; k < s.len() && k < 54; k++) img[k] = s[k] - 8'h20;
        img[61] = pre; img[62] = tap; img[63] = seed;
        for (int k = 0; k < 64; k++) host_write(8'(k), img[k]);
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 1000) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    // R2 R3 R4 R5 R6 R7: expected frame computed from the bench image
    task automatic verify(input string tag);
        int p;
        logic [6:0] s;
        logic [6:0] t;
        logic [7:0] ch, e, got;
        p = (img[61] < 10) ? 10 : (img[61] > 26) ? 26 : int'(img[61]);
        s = (img[63][6:0] == 0) ? 7'd1 : img[63][6:0];
        t = img[62][6:0];
        for (int i = 0; i < 64; i++) begin
            ch = (i >= p) ? img[i-p] : 8'h00;
            e  = {1'b0, ch[6:0] ^ s};
            s  = {s[5:0], ^(s & t)};
            host_read(8'(64 + i), got);
            chk(got == e, {tag, " R5 R6 R7 frame byte"}, got, e);
            chk(got[7] == 1'b0, "R7 bit7 clear", got[7], 0);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(done == 1'b0, "R1 done low in reset", done, 0);
        @(negedge clk); rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(done == 1'b0, "R1 idle after reset", done, 0);
        host_write(8'd150, 8'h3C);
        host_read(8'd150, v);
        chk(v == 8'h3C, "R1 host access while idle", v, 8'h3C);
    endtask

    task automatic t_basic();
        int n;
        logic [7:0] v;
        load("Mr. Hello, it is a test.", 8'd12, 8'h60, 8'h01);
        kick();
        wait_done(n);
        chk(n == LATENCY, "R8 done latency", n, LATENCY);
        verify("basic R2");
        for (int k = 0; k < 64; k++) begin
            host_read(8'(k), v);
            chk(v == img[k], "R10 low region untouched", v, img[k]);
        end
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R8 done holds", done, 1);
    endtask

    task automatic t_clamp_low();
        int n;
        load("abc XYZ 0123", 8'd3, 8'h7B, 8'h00);
        kick();
        wait_done(n);
        verify("clamp low R3 zero seed R4");
    endtask

    task automatic t_clamp_high();
        int n;
        load("The quick brown fox jumps over the lazy dog again!!!!!", 8'd200, 8'h5C, 8'h80);
        kick();
        wait_done(n);
        verify("clamp high R3 seed msb R4");
    endtask

    task automatic t_abort();
        int n;
        load("abort then rerun", 8'd20, 8'h69, 8'h2D);
        kick();
        repeat (40) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9 done low while start held", done, 0);
        start = 1'b0;
        wait_done(n);
        chk(n == LATENCY, "R9 restart latency", n, LATENCY);
        verify("abort R9");
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [7:0] v;
        host_write(8'd200, 8'h11);
        load("ignore", 8'd15, 8'h48, 8'h7F);
        kick();
        repeat (10) @(negedge clk);
        host_we = 1'b1; host_addr = 8'd200; host_wdata = 8'hAA;
        @(negedge clk);
        host_we = 1'b0;
        wait_done(n);
        host_read(8'd200, v);
        chk(v == 8'h11, "R11 host write ignored while busy", v, 8'h11);
        verify("busy R11");
    endtask

    task automatic t_reset_mid();
        kick();
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done == 1'b0, "R1 done low after mid reset", done, 0);
        repeat (200) @(negedge clk);
        chk(done == 1'b0, "R1 stays idle after mid reset", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_clamp_low();
        t_clamp_high();
        t_abort();
        t_busy_ignore();
        t_reset_mid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule